// File: doc/BRIEF.md
# Control-Store Bit-Verification Sequencer

This block walks a read-only control store one bit at a time and checks every bit of every word against an expected response, without using a comparator. For each bit under test it loads the store word into a data register, then ORs in a mask that holds ones everywhere except at the tested position. An all-ones test on the result toggles a single trigger when the tested bit is 1. The expected word then goes through the same load, mask and all-ones test, and the trigger toggles again when its bit is 1. When both tests are done, the trigger holds the exclusive-OR of the two bits.

If the trigger is off, the block moves to the next bit. If it is on, the block enters a diagnostic stop. It freezes its address, loads the failing word address and bit index into the data register for display, and waits. A rising edge on the start input resumes testing at the next bit. The sweep runs bit 0 to the top bit within each word, then moves to the next word. After the last bit of the last word, a sticky done flag rises. A counter records how many diagnostic stops occurred.

Top module: `csbv_top`

## Requirements
- R1: While reset is held, the store address is 0 and stop, done and the stop count are all 0.
- R2: Bits are tested in ascending bit index (0 to WIDTH-1) within a word before the word address increments, so diagnostic stops appear in that order.
- R3: A diagnostic stop occurs for a bit exactly when the stored bit and the expected bit differ. Equal bits, 1/1 or 0/0, never stop.
- R4: Bits other than the one under test have no effect on the result. Words of all zeros or all ones, with matching expected words, produce no stop.
- R5: The trigger is cleared at the start of each bit test, so a failing bit does not make the following bit of the same word fail.
- R6: During a stop the store address is held. The data register shows the word address in bits [AW+BW-1:BW] and the bit index in bits [BW-1:0], with zeros above. Here BW = clog2(WIDTH) and AW = clog2(DEPTH).
- R7: Only a rising edge of start resumes a stop, and each edge resumes exactly once. If start is held high into the next stop, that stop is not released.
- R8: Done rises after the last bit of the last word is passed or resumed past, and it stays high until reset.
- R9: The stop count increments by one on entry to each diagnostic stop and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Resume request; its rising edge releases a stop |
| cs_word_i | input | WIDTH | Store output word at cs_addr_o (combinational read) |
| cs_expect_i | input | WIDTH | Expected response word for cs_addr_o |
| cs_addr_o | output | AW | Word address under test |
| data_reg_o | output | WIDTH | Data register; shows the failing address and bit index while stopped |
| stop_o | output | 1 | Diagnostic stop active |
| done_o | output | 1 | Sweep complete (sticky) |
| stop_count_o | output | CNT_W | Number of diagnostic stops taken |

## Verification
The bench uses a small 8-bit by 4-word store and drives four store images. The first is a fault-free image with all-zero and all-ones words; it shows that untested bits never leak into the result and that 1/1 and 0/0 pairs pass. The second and third are single-line faults, stuck-at-1 on bit 3 and stuck-at-0 on bit 6; each must stop once in every word at exactly that bit, which tells the two toggle paths apart. The fourth corrupts bits 0 and 7 of a single word; it exposes ordering errors and any trigger state that carries over between tests. The bench computes every expected stop, its displayed address and bit, and the final count from the images alone. It also holds start high through one stop to confirm that a level does not release the next stop.

// File: rtl/csbv_pkg.sv
package csbv_pkg;
    typedef enum logic [3:0] {
        ST_LOAD_ACT,
        ST_MASK_ACT,
        ST_TEST_ACT,
        ST_LOAD_EXP,
        ST_MASK_EXP,
        ST_TEST_EXP,
        ST_DECIDE,
        ST_HALT,
        ST_FINISH
    } csbv_state_e;
endpackage

// File: rtl/csbv_edge.sv
module csbv_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);
    logic level_d, level_q;

    always_comb begin
        level_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) level_q <= 1'b1;
        else         level_q <= level_d;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/csbv_bitcheck.sv
module csbv_bitcheck #(
    parameter int WIDTH = 32,
    localparam int BW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] reg_i,
    input  logic [BW-1:0]    bit_idx_i,
    output logic [WIDTH-1:0] ored_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             all_ones_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign mask_o[g] = (bit_idx_i != BW'(g));
    end

    assign ored_o     = reg_i | mask_o;
    assign all_ones_o = &reg_i;
endmodule

// File: rtl/csbv_top.sv
module csbv_top #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    parameter int CNT_W = 16,
    localparam int BW = $clog2(WIDTH),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] cs_word_i,
    input  logic [WIDTH-1:0] cs_expect_i,
    output logic [AW-1:0]    cs_addr_o,
    output logic [WIDTH-1:0] data_reg_o,
    output logic             stop_o,
    output logic             done_o,
    output logic [CNT_W-1:0] stop_count_o
);
    import csbv_pkg::*;

    localparam logic [BW-1:0]    LAST_BIT  = BW'(WIDTH - 1);
    localparam logic [AW-1:0]    LAST_WORD = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        csbv_state_e      state;
        logic [AW-1:0]    addr;
        logic [BW-1:0]    bidx;
        logic [WIDTH-1:0] sdr;
        logic             trig;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic             rise;
    logic [WIDTH-1:0] ored;
    logic [WIDTH-1:0] mask;
    logic             all_ones;
    logic             advance;

    csbv_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (start_i),
        .rise_o  (rise)
    );

    csbv_bitcheck #(.WIDTH(WIDTH)) u_check (
        .reg_i      (r_q.sdr),
        .bit_idx_i  (r_q.bidx),
        .ored_o     (ored),
        .mask_o     (mask),
        .all_ones_o (all_ones)
    );

    always_comb begin
        r_d     = r_q;
        advance = 1'b0;
        unique case (r_q.state)
            ST_LOAD_ACT: begin
                r_d.sdr   = cs_word_i;
                r_d.trig  = 1'b0;
                r_d.state = ST_MASK_ACT;
            end
            ST_MASK_ACT: begin
                r_d.sdr   = ored;
                r_d.state = ST_TEST_ACT;
            end
            ST_TEST_ACT: begin
                if (all_ones) r_d.trig = ~r_q.trig;
                r_d.state = ST_LOAD_EXP;
            end
            ST_LOAD_EXP: begin
                r_d.sdr   = cs_expect_i;
                r_d.state = ST_MASK_EXP;
            end
            ST_MASK_EXP: begin
                r_d.sdr   = ored;
                r_d.state = ST_TEST_EXP;
            end
            ST_TEST_EXP: begin
                if (all_ones) r_d.trig = ~r_q.trig;
                r_d.state = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (r_q.trig) begin
                    r_d.state = ST_HALT;
                    r_d.sdr   = WIDTH'({r_q.addr, r_q.bidx});
                    if (r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_HALT:   advance = rise;
            ST_FINISH: ;
            default:   r_d.state = ST_FINISH;
        endcase

        if (advance) begin
            r_d.state = ST_LOAD_ACT;
            if (r_q.bidx == LAST_BIT) begin
                r_d.bidx = '0;
                if (r_q.addr == LAST_WORD) r_d.state = ST_FINISH;
                else                       r_d.addr  = r_q.addr + 1'b1;
            end else begin
                r_d.bidx = r_q.bidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_LOAD_ACT;
            r_q.addr  <= '0;
            r_q.bidx  <= '0;
            r_q.sdr   <= '0;
            r_q.trig  <= 1'b0;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_addr_o    = r_q.addr;
    assign data_reg_o   = r_q.sdr;
    assign stop_o       = (r_q.state == ST_HALT);
    assign done_o       = (r_q.state == ST_FINISH);
    assign stop_count_o = r_q.cnt;

    // R4
    mask_one_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(mask) == WIDTH - 1);

    // R5
    trig_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_LOAD_ACT) |=> !r_q.trig);

    // R6
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_o && !rise) |=> (stop_o && $stable(cs_addr_o) && $stable(data_reg_o)));

    // R7
    resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_o && rise) |=> !stop_o);

    // R8
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o);

    // R9
    stop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(stop_o) && $past(stop_count_o) != CNT_MAX) |-> stop_count_o == $past(stop_count_o) + 1'b1);
endmodule

// File: tb/csbv_top_test.sv
module csbv_top_test;
    localparam int W  = 8;
    localparam int D  = 4;
    localparam int CW = 8;
    localparam int BW = $clog2(W);
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  word, expect_w;
    logic [AW-1:0] addr;
    logic [W-1:0]  dreg;
    logic          stop, done;
    logic [CW-1:0] cnt;
    int            mode = 0;
    int            total = 0;
    int            bad = 0;
    int            ticks = 0;

    always #5 clk = ~clk;

    csbv_top #(.WIDTH(W), .DEPTH(D), .CNT_W(CW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .cs_word_i(word), .cs_expect_i(expect_w),
        .cs_addr_o(addr), .data_reg_o(dreg), .stop_o(stop),
        .done_o(done), .stop_count_o(cnt)
    );

    function automatic logic [W-1:0] base_w(int a);
        return W'(a * 8'h5B) ^ 8'hA5;
    endfunction

    function automatic logic [W-1:0] exp_f(int m, int a);
        case (m)
            1: return base_w(a) & ~8'h08;
            2: return base_w(a) | 8'h40;
            default: return (a == 0) ? 8'h00 : (a == 1) ? 8'hFF : base_w(a);
        endcase
    endfunction

    function automatic logic [W-1:0] act_f(int m, int a);
        case (m)
            1: return exp_f(m, a) | 8'h08;
            2: return exp_f(m, a) & ~8'h40;
            3: return (a == 2) ? exp_f(m, a) ^ 8'h81 : exp_f(m, a);
            default: return exp_f(m, a);
        endcase
    endfunction

    function automatic bit mism(int m, int a, int b);
        logic [W-1:0] x;
        x = act_f(m, a) ^ exp_f(m, a);
        return x[b];
    endfunction

    always_comb begin
        word     = act_f(mode, int'(addr));
        expect_w = exp_f(mode, int'(addr));
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", ticks);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_phase(int m, bit hold_test, string req);
        int pos = 0;
        int stops = 0;
        int expected_total = 0;
        int cyc = 0;
        int hold_addr;
        for (int p = 0; p < W * D; p++) if (mism(m, p / W, p % W)) expected_total++;
        mode = m;
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(addr == 0 && !stop && !done && cnt == 0, "R1", "reset state",
            {addr, stop, done, cnt}, 0);
        rst_n = 1'b1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (stop) begin
                while (pos < W * D && !mism(m, pos / W, pos % W)) pos++;
                if (pos >= W * D) begin
                    chk(0, req, "unexpected stop", int'(dreg), 0);
                end else begin
                    chk(int'(addr) == pos / W, "R2", "stop address", int'(addr), pos / W);
                    chk(dreg == W'(((pos / W) << BW) | (pos % W)), "R6", "displayed addr/bit",
                        int'(dreg), ((pos / W) << BW) | (pos % W));
                    chk(int'(dreg[BW-1:0]) == pos % W, req, "failing bit", int'(dreg[BW-1:0]), pos % W);
                    pos++;
                end
                stops++;
                chk(int'(cnt) == stops, "R9", "stop count", int'(cnt), stops);
                if (hold_test && stops == 2) begin
                    hold_addr = int'(addr);
                    repeat (20) @(negedge clk);
                    chk(stop && int'(addr) == hold_addr, "R7", "held start must not release",
                        {stop, addr}, {1'b1, hold_addr[AW-1:0]});
                    start = 1'b0;
                    @(negedge clk);
                end
                start = 1'b1;
                @(negedge clk);
                @(negedge clk);
                if (!(hold_test && stops == 1)) start = 1'b0;
                chk(!stop, "R7", "edge resumes", stop, 0);
                while (stop && cyc < 5000) begin
                    @(negedge clk);
                    cyc++;
                end
            end
        end
        start = 1'b0;
        chk(done, "R8", "done after sweep", done, 1);
        while (pos < W * D && !mism(m, pos / W, pos % W)) pos++;
        chk(pos >= W * D, "R3", "missed stop position", pos, W * D);
        chk(stops == expected_total, req, "number of stops", stops, expected_total);
        chk(int'(cnt) == expected_total, "R9", "final count", int'(cnt), expected_total);
        repeat (5) @(negedge clk);
        chk(done && !stop, "R8", "done sticky", {done, stop}, 2);
    endtask

    initial begin
        run_phase(0, 1'b0, "R4");
        run_phase(1, 1'b1, "R3");
        run_phase(2, 1'b0, "R3");
        run_phase(3, 1'b0, "R5");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule